// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Generator

This block is an 8-bit up-counter with one compare channel and a waveform generator that drives a single output pin. A clock-enable input stands in for the prescaled timer tick, so the counter advances only on cycles where `tick` is high. A two-bit counting-mode field selects how the counter runs. In free-running mode it wraps from 0xFF to 0x00. In clear-on-compare mode the compare value acts as the top of the count. In single-slope PWM mode the counter runs the full 0x00 to 0xFF range.

A two-bit pin-action field selects what the pin does on a compare match. It can toggle, clear, set or hold. In PWM mode the same field chooses a non-inverted output, an inverted output, or no output action. Software reaches the block through a flat four-register port. Writes take one clock. Reads are combinational.

Two sticky flags record events: counter wrap and compare match. Writing a 1 to a flag bit clears it. A force strobe in the control register applies the pin action at once, without waiting for a match. It works only in the non-PWM modes.

Top module: `cm_timer`

## Requirements
- R1: After reset the counter, compare register, control fields and both flags read 0, and `wave_out` is 0.
- R2: In counting mode 0, and in the reserved mode 1, the counter adds one on each cycle with `tick` high and never clears on a match. It wraps from 0xFF to 0x00. With `tick` low the counter holds.
- R3: In every counting mode, the tick that takes the counter from 0xFF to 0x00 sets the wrap flag (flags bit 0) at the same clock edge. Hardware never clears this flag.
- R4: In counting mode 2, a tick with the counter equal to the compare register loads 0 into the counter and sets the match flag (flags bit 1). A compare value C therefore gives a period of C+1 ticks.
- R5: In counting mode 2 the compare register is used as written, with no buffering. If it is lowered below the current count, no match occurs until the counter runs through 0xFF and wraps to 0x00.
- R6: In modes 0, 1 and 2, a match applies the pin action. Action 1 toggles `wave_out`, action 2 clears it, action 3 sets it and action 0 leaves it unchanged. A match sets the match flag in every mode.
- R7: In counting mode 3 (PWM), action 2 sets the pin when the counter wraps to 0 and clears it on a match. Action 3 does the reverse. Actions 0 and 1 leave the pin unchanged. When the wrap and the match fall on the same tick, the wrap action wins. So with compare C, action 2 keeps the pin high for C+1 of every 256 ticks, and action 3 keeps it high for 255-C.
- R8: In counting mode 3 the compare value used for matching is taken from the compare register only on the tick where the counter wraps to 0. Reads of the compare register always return the last value written.
- R9: A control write with bit 7 set, whose written mode field is not 3, applies the written pin action to `wave_out` at that edge. It does not set the match flag and does not change the counter. When the written mode field is 3, bit 7 has no effect.
- R10: Writing the flags register clears each flag whose data bit is 1 and leaves the others alone. If a set event falls in the same cycle as a clearing write, the flag ends up set.
- R11: A counter write loads the written value. In that cycle the tick is ignored: there is no step, no match and no wrap.
- R12: Register map, selected by a 2-bit address:
  - address 0 is control: bits [1:0] hold the counting mode, bits [3:2] hold the pin action, and bit 7 is the force strobe, which always reads 0.
  - address 1 is the counter.
  - address 2 is the compare register.
  - address 3 is flags: bit 0 is the wrap flag and bit 1 is the match flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data, combinational |
| wave_out | output | 1 | Waveform output pin |

## Verification
The bench targets the wrap-versus-match collision in PWM mode, using compare values of 0 and 0xFF in both polarities. A design that gave the match priority would produce a pin stuck low instead of high, or emit a one-tick glitch. It also lowers the clear-on-compare top below the running count. A design that compared with `>=` would clear early instead of running through the wrap. In PWM mode, the bench rewrites the compare register in mid-period to catch a design that uses the new value at once. It also issues force strobes in PWM mode, and a flag clear that coincides with a wrap, to catch a design that drops the event.

// File: rtl/cm_timer.sv
module cm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         wave_out
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CMP = 2'd2, A_FLG = 2'd3;

  logic [W-1:0] cnt, cmp_reg, cmp_buf;
  logic [1:0]   mode, act;
  logic         wrap_f, match_f, out_q;

  wire ctrl_wr = wr_en && wr_addr == A_CTRL;
  wire cnt_wr  = wr_en && wr_addr == A_CNT;
  wire cmp_wr  = wr_en && wr_addr == A_CMP;
  wire flg_wr  = wr_en && wr_addr == A_FLG;

  wire pwm  = mode == 2'd3;
  wire ctc  = mode == 2'd2;
  wire step = tick && !cnt_wr;

  wire [W-1:0] cmp_use = pwm ? cmp_buf : cmp_reg;
  wire [W-1:0] cmp_nxt = cmp_wr ? wr_data : cmp_reg;
  wire hit  = step && cnt == cmp_use;
  wire wrap = step && cnt == MAX;
  wire force_go = ctrl_wr && wr_data[7] && wr_data[1:0] != 2'd3;

  function automatic logic apply(input logic [1:0] a, input logic cur);
    case (a)
      2'd1:    return ~cur;
      2'd2:    return 1'b0;
      2'd3:    return 1'b1;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= wr_data;
    end else if (step) begin
      cnt <= (ctc && hit) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_reg <= '0;
      cmp_buf <= '0;
    end else begin
      cmp_reg <= cmp_nxt;
      if (!pwm || wrap) cmp_buf <= cmp_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      act  <= '0;
    end else if (ctrl_wr) begin
      mode <= wr_data[1:0];
      act  <= wr_data[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (force_go) begin
      out_q <= apply(wr_data[3:2], out_q);
    end else if (pwm) begin
      if (wrap && act[1])      out_q <= ~act[0];
      else if (hit && act[1])  out_q <= act[0];
    end else if (hit) begin
      out_q <= apply(act, out_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_f  <= 1'b0;
      match_f <= 1'b0;
    end else begin
      wrap_f  <= wrap | (wrap_f  & ~(flg_wr & wr_data[0]));
      match_f <= hit  | (match_f & ~(flg_wr & wr_data[1]));
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[3:0] = {act, mode};
      A_CNT:   rd_data = cnt;
      A_CMP:   rd_data = cmp_reg;
      default: rd_data[1:0] = {match_f, wrap_f};
    endcase
  end

  assign wave_out = out_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(cnt)); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    step && cnt == MAX |=> wrap_f && cnt == '0); // R3
  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    step && ctc && cnt == cmp_reg |=> cnt == '0); // R4
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> match_f); // R6
  AST_PWM_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    pwm && act == 2'd2 && wrap && !ctrl_wr |=> wave_out); // R7
  AST_PWM_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwm && !wrap |=> $stable(cmp_buf)); // R8
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    force_go && !tick && !match_f |=> !match_f); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flg_wr && wrap_f |=> wrap_f); // R10
endmodule

// File: tb/cm_timer_tb.sv
module cm_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wave_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam int NV = 6;
  localparam int VEC_ACT [NV] = '{2, 2, 2, 3, 3, 3};
  localparam int VEC_CMP [NV] = '{0, 127, 255, 0, 200, 255};
  localparam int VEC_HIGH[NV] = '{1, 128, 256, 255, 55, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  cm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wave_out(wave_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a;
    #1 d = int'(rd_data);
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int v;
    int highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset register", v, 0);
    end
    chk("R1 reset wave_out", int'(wave_out), 0);

    wr(0, 8'h8E);
    rd(0, v); chk("R12 control readback, strobe reads 0", v, 8'h0E);
    chk("R9 force set", int'(wave_out), 1);
    rd(3, v); chk("R9 force leaves match flag", v, 0);
    rd(1, v); chk("R9 force leaves counter", v, 0);
    wr(0, 8'h88); chk("R9 force clear", int'(wave_out), 0);
    wr(0, 8'h84); chk("R9 force toggle", int'(wave_out), 1);
    wr(0, 8'h80); chk("R9 force with action 0", int'(wave_out), 1);
    wr(0, 8'h8B); chk("R9 force ignored in PWM", int'(wave_out), 1);

    wr(0, 8'h01);
    wr(1, 8'hFE);
    run(1); rd(1, v); chk("R2 reserved mode counts", v, 8'hFF);
    rd(3, v); chk("R3 no wrap flag before wrap", v, 0);
    run(1); rd(1, v); chk("R2 wrap to zero", v, 0);
    rd(3, v); chk("R3 wrap flag set", v & 1, 1);
    run(3); rd(1, v); chk("R2 no clear on match", v, 3);
    chk("R6 action 0 leaves pin", int'(wave_out), 1);
    repeat (2) @(negedge clk);
    rd(1, v); chk("R2 hold without tick", v, 3);

    wr(3, 8'h01); rd(3, v); chk("R10 partial clear", v, 2);
    wr(3, 8'h02); rd(3, v); chk("R10 clear match flag", v, 0);
    wr(1, 8'hFF);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3, v); chk("R10 set wins over clear", v & 1, 1);

    wr(0, 8'h8C);
    wr(0, 8'h08); wr(2, 8'd10); wr(1, 8'd5); wr(3, 8'h03);
    run(5); rd(1, v); chk("R6 before match", v, 10);
    chk("R6 pin before match", int'(wave_out), 1);
    run(1); chk("R6 clear on match", int'(wave_out), 0);
    rd(1, v); chk("R2 normal passes compare", v, 11);
    rd(3, v); chk("R6 match flag", v, 2);
    wr(0, 8'h0C); wr(1, 8'd9);
    run(2); chk("R6 set on match", int'(wave_out), 1);

    wr(0, 8'h06); wr(2, 8'd4); wr(1, 8'd0); wr(3, 8'h03);
    run(4); rd(1, v); chk("R4 reaches top", v, 4);
    chk("R6 no toggle before match", int'(wave_out), 1);
    run(1); rd(1, v); chk("R4 clear at top", v, 0);
    chk("R6 toggle on match", int'(wave_out), 0);
    rd(3, v); chk("R4 match flag", v, 2);
    run(5); chk("R6 toggle period", int'(wave_out), 1);

    wr(2, 8'd200); wr(1, 8'd0); wr(3, 8'h03);
    run(150); rd(1, v); chk("R5 count below top", v, 150);
    wr(2, 8'd100);
    run(105); rd(1, v); chk("R5 runs past lowered top", v, 255);
    rd(3, v); chk("R5 no match yet", v, 0);
    run(1); rd(3, v); chk("R3 wrap flag in CTC", v, 1);
    run(100); rd(1, v); chk("R5 reaches new top", v, 100);
    run(1); rd(1, v); chk("R5 clear after wrap", v, 0);
    rd(3, v); chk("R5 match after wrap", v & 2, 2);

    wr(0, 8'h00);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h40;
    @(negedge clk);
    wr_en = 1'b0;
    rd(1, v); chk("R11 write overrides tick", v, 8'h40);
    @(negedge clk);
    tick = 1'b0;
    rd(1, v); chk("R11 counting resumes", v, 8'h41);

    for (int i = 0; i < NV; i++) begin
      wr(0, 8'h00);
      wr(2, 8'(VEC_CMP[i]));
      wr(0, 8'((VEC_ACT[i] << 2) | 3));
      wr(1, 8'hFF);
      highs = 0;
      tick = 1'b1;
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        if (wave_out) highs++;
      end
      tick = 1'b0;
      chk($sformatf("R7 PWM duty vector %0d", i), highs, VEC_HIGH[i]);
    end
    wr(0, 8'h07);
    run(300); chk("R7 action 1 no output in PWM", int'(wave_out), 0);

    wr(0, 8'h00); wr(2, 8'd100); wr(0, 8'h0B); wr(1, 8'hFF);
    run(51); chk("R8 high after bottom", int'(wave_out), 1);
    wr(2, 8'd150);
    run(70); chk("R8 old compare still used", int'(wave_out), 0);
    rd(2, v); chk("R8 compare reads new value", v, 150);
    run(136); rd(1, v); chk("R8 wrapped", v, 0);
    chk("R8 set at bottom", int'(wave_out), 1);
    run(120); chk("R8 new compare not yet matched", int'(wave_out), 1);
    run(40); chk("R8 new compare matched", int'(wave_out), 0);

    finish_up();
  end
endmodule